// File: doc/BRIEF.md
# Miss-Tagged Slice Reschedule Buffer

This block keeps a shadow copy of every instruction that an execution cluster receives, grouped by the slice it belongs to. When a slice finishes, the cluster reports whether a long-latency miss occurred. A clean slice's copies are discarded. A slice that missed is moved into a parking store, tagged with the identifier of the miss that blocked it. When the memory side reports that this miss has returned, the parked slice becomes eligible. It is then streamed back out, one instruction per cycle, so it can be executed again.

One instance serves one cluster. Its front end is a circular shadow queue that is written at issue time. Entries are retired or moved from the queue head by a fill state machine with the states FL_IDLE, FL_COPY and FL_STALL:
- FL_IDLE moves to FL_COPY when a free slot exists.
- FL_IDLE moves to FL_STALL when no slot is free.
- FL_STALL moves to FL_COPY once a slot frees up.
- FL_COPY moves back to FL_IDLE when the slice ends or the slot is full.

Each parking slot steps through SL_FREE, SL_FILL, SL_WAIT and SL_READY. It moves straight from SL_FILL to SL_READY if its miss returned while the slot was still filling. A replay state machine has two states. RP_IDLE picks the oldest ready slot and moves to RP_EMIT. RP_EMIT streams that slot and returns to RP_IDLE after the slot's last accepted instruction.

Issue assumptions: a slice's instructions are issued back to back, and its completion arrives after its last issue. A slice ID is not reused while any of its entries are still pending.

Top module: `slice_replay_buf`

## Requirements
- R1: The shadow queue holds 32 entries. `q_full` is 1 exactly when 32 issued entries are still held, and it drops once those entries have been retired.
- R2: A slice completed with `cmp_miss`=0 never appears on the replay port.
- R3: A slice completed with `cmp_miss`=1 is replayed in full, in issue order, carrying its own slice ID on `rep_slice`.
- R4: A parked slice is not replayed before a return whose `ret_miss_id` equals its tag. A return with any other ID has no effect on it.
- R5: A single return releases every parked slice tagged with that miss ID.
- R6: Among slices that are eligible at the same time, replay goes oldest-first by the order in which they were parked.
- R7: Replay moves one instruction per cycle when `rep_valid` and `rep_ready` are both 1. While `rep_ready` is 0, `rep_valid`, `rep_instr` and `rep_slice` hold their values.
- R8: The parking store has 8 slots. If a missed slice reaches the queue head while all slots are taken, `park_stall` is 1 and the slice is kept. The slice is parked, and `park_stall` drops, once a slot frees.
- R9: A parked slice of 16 instructions, the per-slot maximum, is replayed complete.
- R10: After reset, `rep_valid`, `park_stall` and `q_full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is issued to the cluster this cycle |
| iss_slice | input | 4 | Slice ID of the issued instruction |
| iss_instr | input | 32 | Issued instruction word |
| cmp_valid | input | 1 | A slice has finished executing |
| cmp_slice | input | 4 | Slice ID of the finished slice |
| cmp_miss | input | 1 | 1: the slice hit a long-latency miss; 0: it finished clean |
| cmp_miss_id | input | 4 | Identifier of the miss, used when `cmp_miss` is 1 |
| ret_valid | input | 1 | A miss has returned its data |
| ret_miss_id | input | 4 | Identifier of the returned miss |
| rep_valid | output | 1 | A replay instruction is offered |
| rep_ready | input | 1 | The downstream side accepts the replay instruction |
| rep_slice | output | 4 | Slice ID of the replay instruction |
| rep_instr | output | 32 | Replay instruction word |
| q_full | output | 1 | The shadow queue is full; issue must pause |
| park_stall | output | 1 | A missed slice is waiting for a free parking slot |

## Verification
A slot stuck in the wrong state shows up at the replay port. The slice is either never replayed after its miss returns, or it appears before the return. Either fault is visible within a few cycles of the return. An age-ordering fault shows up as slices leaving in the wrong order as soon as two of them become eligible together. A queue pointer or marking fault shows up as lost, duplicated or reordered instructions in the next replayed slice. It can also show as `q_full` failing to clear within a cycle of the head entries being retired.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [1:0] {
        QS_PEND,
        QS_DONE,
        QS_MOVE
    } q_st_e;

    typedef enum logic [1:0] {
        FL_IDLE,
        FL_COPY,
        FL_STALL
    } fill_st_e;

    typedef enum logic [1:0] {
        SL_FREE,
        SL_FILL,
        SL_WAIT,
        SL_READY
    } slot_st_e;

    typedef enum logic {
        RP_IDLE,
        RP_EMIT
    } rep_st_e;

endpackage

// File: rtl/srb_shadow_q.sv
module srb_shadow_q
    import srb_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int INSTR_W = 32,
    parameter int SID_W   = 4,
    parameter int MID_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SID_W-1:0]   wr_sid,
    input  logic [INSTR_W-1:0] wr_instr,
    input  logic               cmp_valid,
    input  logic [SID_W-1:0]   cmp_sid,
    input  logic               cmp_miss,
    input  logic [MID_W-1:0]   cmp_mid,
    input  logic               pop,
    output logic               full,
    output logic               empty,
    output logic [INSTR_W-1:0] hd_instr,
    output logic [SID_W-1:0]   hd_sid,
    output q_st_e              hd_st,
    output logic [MID_W-1:0]   hd_mid
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [INSTR_W-1:0] e_instr [DEPTH];
    logic [SID_W-1:0]   e_sid   [DEPTH];
    logic [MID_W-1:0]   e_mid   [DEPTH];
    q_st_e              e_st    [DEPTH];
    logic [DEPTH-1:0]   e_vld;

    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;

    assign full     = (cnt == CNT_W'(DEPTH));
    assign empty    = (cnt == '0);
    assign hd_instr = e_instr[rp];
    assign hd_sid   = e_sid[rp];
    assign hd_st    = e_st[rp];
    assign hd_mid   = e_mid[rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)   rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CNT_W'(wr_en) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld <= '0;
            for (int i = 0; i < DEPTH; i++) e_st[i] <= QS_PEND;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cmp_valid && e_vld[i] && e_st[i] == QS_PEND && e_sid[i] == cmp_sid) begin
                    e_st[i]  <= cmp_miss ? QS_MOVE : QS_DONE;
                    e_mid[i] <= cmp_mid;
                end
            end
            if (pop) e_vld[rp] <= 1'b0;
            if (wr_en) begin
                e_vld[wp]   <= 1'b1;
                e_st[wp]    <= QS_PEND;
                e_sid[wp]   <= wr_sid;
                e_instr[wp] <= wr_instr;
            end
        end
    end

    AST_Q_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full); // R1
    AST_Q_POP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R1

endmodule

// File: rtl/srb_age_pick.sv
module srb_age_pick #(
    parameter int N     = 8,
    parameter int AGE_W = 3,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     elig,
    input  logic [AGE_W-1:0] age [N],
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic [AGE_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '1;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!any || age[i] < best)) begin
                any  = 1'b1;
                best = age[i];
                idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/srb_park_store.sv
module srb_park_store
    import srb_pkg::*;
#(
    parameter int SLOTS     = 8,
    parameter int SLICE_MAX = 16,
    parameter int INSTR_W   = 32,
    parameter int SID_W     = 4,
    parameter int MID_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               alloc_ok,
    input  logic               alloc,
    input  logic [MID_W-1:0]   alloc_mid,
    input  logic               wr,
    input  logic [INSTR_W-1:0] wr_instr,
    input  logic [SID_W-1:0]   wr_sid,
    input  logic               close,
    input  logic               ret_valid,
    input  logic [MID_W-1:0]   ret_mid,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [INSTR_W-1:0] out_instr,
    output logic [SID_W-1:0]   out_sid
);

    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int AGE_W  = SLOT_W;
    localparam int OCC_W  = $clog2(SLOTS + 1);
    localparam int POS_W  = $clog2(SLICE_MAX);
    localparam int LEN_W  = $clog2(SLICE_MAX + 1);

    logic [INSTR_W-1:0] m_instr [SLOTS][SLICE_MAX];
    logic [SID_W-1:0]   m_sid   [SLOTS][SLICE_MAX];

    slot_st_e          slot_st  [SLOTS];
    logic [LEN_W-1:0]  slot_len [SLOTS];
    logic [AGE_W-1:0]  slot_age [SLOTS];
    logic [SLOTS-1:0]  slot_rdy;

    logic [SLOT_W-1:0] alloc_idx, fill_idx, rp_slot, pick_idx;
    logic [POS_W-1:0]  rp_pos;
    logic [OCC_W-1:0]  occ;
    logic [AGE_W-1:0]  new_age, free_age;
    logic [LEN_W-1:0]  fill_len;
    logic              pick_any, free_ev, rp_last;
    rep_st_e           rp_state, rp_next;

    always_comb begin
        alloc_ok  = 1'b0;
        alloc_idx = '0;
        occ       = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (slot_st[i] == SL_FREE) begin
                alloc_ok  = 1'b1;
                alloc_idx = SLOT_W'(i);
            end else begin
                occ = occ + 1'b1;
            end
        end
    end

    assign fill_len = slot_len[fill_idx];
    assign free_age = slot_age[rp_slot];
    assign rp_last  = ((LEN_W'(rp_pos) + LEN_W'(1)) == slot_len[rp_slot]);
    assign free_ev  = (rp_state == RP_EMIT) && out_ready && rp_last;
    assign new_age  = AGE_W'(occ - OCC_W'(free_ev));

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            slot_st_e         st_q;
            logic             rel_q;
            logic [MID_W-1:0] mid_q;
            logic [LEN_W-1:0] len_q;
            logic [AGE_W-1:0] age_q;
            logic             hit, mine;

            assign hit  = ret_valid && (ret_mid == mid_q);
            assign mine = (fill_idx == SLOT_W'(g));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q  <= SL_FREE;
                    rel_q <= 1'b0;
                    mid_q <= '0;
                    len_q <= '0;
                    age_q <= '0;
                end else begin
                    if (free_ev && st_q != SL_FREE && age_q > free_age)
                        age_q <= age_q - 1'b1;
                    unique case (st_q)
                        SL_FREE: begin
                            if (alloc && alloc_idx == SLOT_W'(g)) begin
                                st_q  <= SL_FILL;
                                mid_q <= alloc_mid;
                                len_q <= '0;
                                rel_q <= 1'b0;
                                age_q <= new_age;
                            end
                        end
                        SL_FILL: begin
                            if (wr && mine) len_q <= len_q + 1'b1;
                            if (hit) rel_q <= 1'b1;
                            if (close && mine)
                                st_q <= (rel_q || hit) ? SL_READY : SL_WAIT;
                        end
                        SL_WAIT: begin
                            if (hit) st_q <= SL_READY;
                        end
                        SL_READY: begin
                            if (free_ev && rp_slot == SLOT_W'(g)) st_q <= SL_FREE;
                        end
                    endcase
                end
            end

            assign slot_st[g]  = st_q;
            assign slot_len[g] = len_q;
            assign slot_age[g] = age_q;
            assign slot_rdy[g] = (st_q == SL_READY);
        end
    endgenerate

    srb_age_pick #(
        .N     (SLOTS),
        .AGE_W (AGE_W),
        .IDX_W (SLOT_W)
    ) u_pick (
        .elig (slot_rdy),
        .age  (slot_age),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (wr) begin
            m_instr[fill_idx][fill_len[POS_W-1:0]] <= wr_instr;
            m_sid[fill_idx][fill_len[POS_W-1:0]]   <= wr_sid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_idx <= '0;
        end else if (alloc) begin
            fill_idx <= alloc_idx;
        end
    end

    // replay state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_state <= RP_IDLE;
            rp_slot  <= '0;
            rp_pos   <= '0;
        end else begin
            rp_state <= rp_next;
            if (rp_state == RP_IDLE && pick_any) begin
                rp_slot <= pick_idx;
                rp_pos  <= '0;
            end else if (rp_state == RP_EMIT && out_ready && !rp_last) begin
                rp_pos <= rp_pos + 1'b1;
            end
        end
    end

    // replay next state and outputs
    always_comb begin
        rp_next   = rp_state;
        out_valid = 1'b0;
        unique case (rp_state)
            RP_IDLE: if (pick_any) rp_next = RP_EMIT;
            RP_EMIT: begin
                out_valid = 1'b1;
                if (out_ready && rp_last) rp_next = RP_IDLE;
            end
        endcase
    end

    assign out_instr = m_instr[rp_slot][rp_pos];
    assign out_sid   = m_sid[rp_slot][rp_pos];

    AST_ALLOC_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> alloc_ok); // R8
    AST_REP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_instr) && $stable(out_sid))); // R7
    AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (fill_len < LEN_W'(SLICE_MAX))); // R9
    AST_REP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (slot_st[rp_slot] == SL_READY)); // R4

endmodule

// File: rtl/slice_replay_buf.sv
module slice_replay_buf
    import srb_pkg::*;
#(
    parameter int Q_DEPTH   = 32,
    parameter int SLOTS     = 8,
    parameter int SLICE_MAX = 16,
    parameter int INSTR_W   = 32,
    parameter int SID_W     = 4,
    parameter int MID_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iss_valid,
    input  logic [SID_W-1:0]   iss_slice,
    input  logic [INSTR_W-1:0] iss_instr,
    input  logic               cmp_valid,
    input  logic [SID_W-1:0]   cmp_slice,
    input  logic               cmp_miss,
    input  logic [MID_W-1:0]   cmp_miss_id,
    input  logic               ret_valid,
    input  logic [MID_W-1:0]   ret_miss_id,
    output logic               rep_valid,
    input  logic               rep_ready,
    output logic [SID_W-1:0]   rep_slice,
    output logic [INSTR_W-1:0] rep_instr,
    output logic               q_full,
    output logic               park_stall
);

    localparam int CNT_W = $clog2(SLICE_MAX + 1);

    logic               q_empty, q_pop;
    logic [INSTR_W-1:0] hd_instr;
    logic [SID_W-1:0]   hd_sid;
    q_st_e              hd_st;
    logic [MID_W-1:0]   hd_mid;

    logic alloc_ok, alloc, wr, close;

    fill_st_e         fl_state, fl_next;
    logic [SID_W-1:0] cur_sid;
    logic [CNT_W-1:0] cur_cnt;

    srb_shadow_q #(
        .DEPTH   (Q_DEPTH),
        .INSTR_W (INSTR_W),
        .SID_W   (SID_W),
        .MID_W   (MID_W)
    ) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (iss_valid),
        .wr_sid    (iss_slice),
        .wr_instr  (iss_instr),
        .cmp_valid (cmp_valid),
        .cmp_sid   (cmp_slice),
        .cmp_miss  (cmp_miss),
        .cmp_mid   (cmp_miss_id),
        .pop       (q_pop),
        .full      (q_full),
        .empty     (q_empty),
        .hd_instr  (hd_instr),
        .hd_sid    (hd_sid),
        .hd_st     (hd_st),
        .hd_mid    (hd_mid)
    );

    srb_park_store #(
        .SLOTS     (SLOTS),
        .SLICE_MAX (SLICE_MAX),
        .INSTR_W   (INSTR_W),
        .SID_W     (SID_W),
        .MID_W     (MID_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_ok  (alloc_ok),
        .alloc     (alloc),
        .alloc_mid (hd_mid),
        .wr        (wr),
        .wr_instr  (hd_instr),
        .wr_sid    (hd_sid),
        .close     (close),
        .ret_valid (ret_valid),
        .ret_mid   (ret_miss_id),
        .out_valid (rep_valid),
        .out_ready (rep_ready),
        .out_instr (rep_instr),
        .out_sid   (rep_slice)
    );

    // fill state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_state <= FL_IDLE;
            cur_sid  <= '0;
            cur_cnt  <= '0;
        end else begin
            fl_state <= fl_next;
            if (alloc) begin
                cur_sid <= hd_sid;
                cur_cnt <= '0;
            end else if (wr) begin
                cur_cnt <= cur_cnt + 1'b1;
            end
        end
    end

    // fill next state and head actions
    always_comb begin
        fl_next    = fl_state;
        q_pop      = 1'b0;
        alloc      = 1'b0;
        wr         = 1'b0;
        close      = 1'b0;
        park_stall = 1'b0;
        unique case (fl_state)
            FL_IDLE: begin
                if (!q_empty && hd_st == QS_DONE) begin
                    q_pop = 1'b1;
                end else if (!q_empty && hd_st == QS_MOVE) begin
                    if (alloc_ok) begin
                        alloc   = 1'b1;
                        fl_next = FL_COPY;
                    end else begin
                        fl_next = FL_STALL;
                    end
                end
            end
            FL_STALL: begin
                park_stall = 1'b1;
                if (alloc_ok) begin
                    alloc   = 1'b1;
                    fl_next = FL_COPY;
                end
            end
            FL_COPY: begin
                if (!q_empty && hd_st == QS_MOVE && hd_sid == cur_sid
                    && cur_cnt < CNT_W'(SLICE_MAX)) begin
                    wr    = 1'b1;
                    q_pop = 1'b1;
                end else begin
                    close   = 1'b1;
                    fl_next = FL_IDLE;
                end
            end
            default: fl_next = FL_IDLE;
        endcase
    end

    AST_DONE_NOT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (hd_st == QS_MOVE)); // R2
    AST_COPY_SAME_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (hd_sid == cur_sid)); // R3
    AST_STALL_HOLDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        park_stall |-> (!q_empty && hd_st == QS_MOVE)); // R8

endmodule

// File: tb/tb_slice_replay_buf.sv
module tb_slice_replay_buf;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        iss_valid;
    logic [3:0]  iss_slice;
    logic [31:0] iss_instr;
    logic        cmp_valid;
    logic [3:0]  cmp_slice;
    logic        cmp_miss;
    logic [3:0]  cmp_miss_id;
    logic        ret_valid;
    logic [3:0]  ret_miss_id;
    logic        rep_valid;
    logic        rep_ready;
    logic [3:0]  rep_slice;
    logic [31:0] rep_instr;
    logic        q_full;
    logic        park_stall;

    int n_chk  = 0;
    int n_fail = 0;

    logic [35:0] exp_q[$];
    string       exp_tag[$];

    always #5 clk = ~clk;

    slice_replay_buf dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .iss_valid   (iss_valid),
        .iss_slice   (iss_slice),
        .iss_instr   (iss_instr),
        .cmp_valid   (cmp_valid),
        .cmp_slice   (cmp_slice),
        .cmp_miss    (cmp_miss),
        .cmp_miss_id (cmp_miss_id),
        .ret_valid   (ret_valid),
        .ret_miss_id (ret_miss_id),
        .rep_valid   (rep_valid),
        .rep_ready   (rep_ready),
        .rep_slice   (rep_slice),
        .rep_instr   (rep_instr),
        .q_full      (q_full),
        .park_stall  (park_stall)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int sid, input int k);
        return 32'hA000_0000 + sid * 256 + k;
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic issue_slice(input int sid, input int n);
        for (int k = 0; k < n; k++) begin
            iss_valid = 1'b1;
            iss_slice = 4'(sid);
            iss_instr = word(sid, k);
            step(1);
        end
        iss_valid = 1'b0;
    endtask

    task automatic complete(input int sid, input bit miss, input int mid);
        cmp_valid   = 1'b1;
        cmp_slice   = 4'(sid);
        cmp_miss    = miss;
        cmp_miss_id = 4'(mid);
        step(1);
        cmp_valid = 1'b0;
    endtask

    task automatic give_back(input int mid);
        ret_valid   = 1'b1;
        ret_miss_id = 4'(mid);
        step(1);
        ret_valid = 1'b0;
    endtask

    task automatic expect_slice(input int sid, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back({4'(sid), word(sid, k)});
            exp_tag.push_back(tag);
        end
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        while (exp_q.size() != 0 && guard < 400) begin
            step(1);
            guard++;
        end
        step(3);
        chk(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'd0);
    endtask

    // monitor: transfers and hold-while-stalled
    logic        was_held = 1'b0;
    logic [35:0] held_val;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (was_held)
                chk(rep_valid && {rep_slice, rep_instr} == held_val, "R7 hold",
                    64'({rep_valid, rep_slice, rep_instr}), 64'({1'b1, held_val}));
            was_held = rep_valid && !rep_ready;
            held_val = {rep_slice, rep_instr};
            if (rep_valid && rep_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R4 unexpected replay", 64'({rep_slice, rep_instr}), 64'd0);
                end else begin
                    logic [35:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = exp_tag.pop_front();
                    chk({rep_slice, rep_instr} == e, t, 64'({rep_slice, rep_instr}), 64'(e));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        iss_valid = 1'b0; iss_slice = '0; iss_instr = '0;
        cmp_valid = 1'b0; cmp_slice = '0; cmp_miss = 1'b0; cmp_miss_id = '0;
        ret_valid = 1'b0; ret_miss_id = '0;
        rep_ready = 1'b1;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R10 reset state
        chk(rep_valid == 1'b0, "R10 rep_valid", 64'(rep_valid), 64'd0);
        chk(park_stall == 1'b0, "R10 park_stall", 64'(park_stall), 64'd0);
        chk(q_full == 1'b0, "R10 q_full", 64'(q_full), 64'd0);

        // R2 clean slice is dropped
        issue_slice(1, 3);
        complete(1, 1'b0, 0);
        step(10);
        chk(rep_valid == 1'b0, "R2 clean slice not replayed", 64'(rep_valid), 64'd0);

        // R3/R4 missed slice waits for its own return
        issue_slice(2, 4);
        complete(2, 1'b1, 5);
        step(10);
        chk(rep_valid == 1'b0, "R4 no replay before return", 64'(rep_valid), 64'd0);
        give_back(7);
        step(5);
        chk(rep_valid == 1'b0, "R4 other miss id ignored", 64'(rep_valid), 64'd0);
        expect_slice(2, 4, "R3 replay in order");
        give_back(5);
        drain("R3 slice fully replayed");

        // R5/R6/R7 shared tag and age order under back-pressure
        rep_ready = 1'b0;
        issue_slice(3, 3);
        complete(3, 1'b1, 2);
        issue_slice(4, 2);
        complete(4, 1'b1, 3);
        issue_slice(5, 2);
        complete(5, 1'b1, 2);
        step(20);
        expect_slice(3, 3, "R6 oldest first");
        expect_slice(4, 2, "R6 age order after later return");
        expect_slice(5, 2, "R5 shared tag released");
        give_back(2);
        step(2);
        give_back(3);
        step(2);
        for (int c = 0; c < 40; c++) begin
            rep_ready = (c % 3) != 0;
            step(1);
        end
        rep_ready = 1'b1;
        drain("R5 all released slices replayed");

        // R8 store full
        for (int s = 0; s < 8; s++) begin
            issue_slice(6 + s, 2);
            complete(6 + s, 1'b1, s);
        end
        issue_slice(14, 2);
        complete(14, 1'b1, 9);
        step(10);
        chk(park_stall == 1'b1, "R8 stall when store full", 64'(park_stall), 64'd1);
        chk(rep_valid == 1'b0, "R8 nothing released yet", 64'(rep_valid), 64'd0);
        expect_slice(6, 2, "R8 first parked slice");
        give_back(0);
        step(15);
        chk(park_stall == 1'b0, "R8 stall clears after slot frees", 64'(park_stall), 64'd0);
        drain("R8 first slice drained");
        expect_slice(14, 2, "R8 kept slice parked later");
        give_back(9);
        drain("R8 kept slice replayed");
        for (int s = 1; s < 8; s++) begin
            expect_slice(6 + s, 2, "R4 tag matched release");
            give_back(s);
            drain("R4 per-tag release");
        end

        // R9 full-length slice
        issue_slice(15, 16);
        complete(15, 1'b1, 10);
        step(25);
        expect_slice(15, 16, "R9 sixteen instructions");
        give_back(10);
        drain("R9 full slice replayed");

        // R1 queue capacity
        issue_slice(1, 16);
        issue_slice(2, 15);
        step(1);
        chk(q_full == 1'b0, "R1 not full at 31", 64'(q_full), 64'd0);
        issue_slice(2, 1);
        step(1);
        chk(q_full == 1'b1, "R1 full at 32", 64'(q_full), 64'd1);
        complete(1, 1'b0, 0);
        complete(2, 1'b0, 0);
        step(10);
        chk(q_full == 1'b0, "R1 full clears after retire", 64'(q_full), 64'd0);
        chk(rep_valid == 1'b0, "R2 clean slices dropped", 64'(rep_valid), 64'd0);
        step(5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule